// File: doc/BRIEF.md
# Modeline-Configurable Raster Timing Generator

This block produces the raster timing for a progressive video output. It runs on the pixel clock and uses two counters. The pixel counter walks along each line. The line counter steps once each time a line ends. From the two counter values the block decodes the horizontal and vertical sync pulses, the data-enable window and a one-clock pulse at the first pixel of each frame. The current pixel and line coordinates are also brought out so that a pixel source can address its data.

Each axis is set by four edge positions, written at run time:

- the end of the visible area,
- the first count of the sync pulse,
- the first count after the pulse,
- the period.

Each sync output also has its own polarity flag. A configuration write goes to a pending copy. That copy becomes the working timing only when the frame wraps, so no frame is ever drawn with mixed timing. A pending copy whose edges are out of order raises an error flag, and it is never promoted: the working timing stays as it was.

For each axis the block reports three values computed from the working timing: the blanking length, the gap from the end of the visible area to the start of sync, and the sync length. Software can compare these with a display's detailed timing data. The frame rate is the pixel clock divided by the product of the two periods. The reset timing is 1920/2008/2052/2200 pixels by 1080/1084/1089/1125 lines, which gives 60 Hz at 148.5 MHz.

Top module: `raster_timing_gen`

## Requirements
- R1: `pix_x` advances by one on every clock and returns to 0 after reaching HTotal-1.
- R2: `pix_y` advances by one in the clock where `pix_x` returns to 0, and returns to 0 after line VTotal-1. It holds its value during a line.
- R3: `de` is high exactly when `pix_x` < HDisp and `pix_y` < VDisp.
- R4: The horizontal pulse covers HSyncStart <= `pix_x` < HSyncEnd, and the vertical pulse covers VSyncStart <= `pix_y` < VSyncEnd. With a polarity flag of 1 the output is high during its pulse and low otherwise.
- R5: With a polarity flag of 0 the sync output is low during its pulse and high otherwise.
- R6: `frame_start` is high for exactly the clocks where `pix_x` = 0 and `pix_y` = 0.
- R7: During reset and afterwards, until the first promotion, the timing is 1920/2008/2052/2200 horizontal and 1080/1084/1089/1125 vertical, both polarity flags are 1, and both counters are 0.
- R8: The derived outputs are computed from the working timing: blank = total - disp, offset = sync start - disp, width = sync end - sync start, for each axis. The reset values are 280/88/44 and 45/4/5.
- R9: A clock with `cfg_write` high captures all ten configuration inputs into the pending copy. The working timing changes only in the clock after the last pixel of the last line, and the frame that follows uses the pending copy held in that last clock.
- R10: An axis is legal when disp >= 1, sync start >= disp, sync end > sync start and sync end <= total. `cfg_error` is high from the clock after an illegal capture until a legal capture. At a frame wrap with an illegal pending copy, the working timing and the derived outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_write | input | 1 | Captures the configuration inputs into the pending copy |
| cfg_hdisp | input | 12 | Visible pixels per line |
| cfg_hsync_start | input | 12 | First pixel of the horizontal pulse |
| cfg_hsync_end | input | 12 | First pixel after the horizontal pulse |
| cfg_htotal | input | 12 | Pixels per line |
| cfg_vdisp | input | 12 | Visible lines per frame |
| cfg_vsync_start | input | 12 | First line of the vertical pulse |
| cfg_vsync_end | input | 12 | First line after the vertical pulse |
| cfg_vtotal | input | 12 | Lines per frame |
| cfg_hsync_pos | input | 1 | 1: horizontal sync is high during its pulse |
| cfg_vsync_pos | input | 1 | 1: vertical sync is high during its pulse |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Visible-area enable |
| frame_start | output | 1 | One-clock pulse at the first pixel of a frame |
| pix_x | output | 12 | Current pixel within the line |
| pix_y | output | 12 | Current line within the frame |
| cfg_error | output | 1 | Pending configuration is illegal |
| h_blank | output | 12 | Horizontal blanking length |
| h_offset | output | 12 | Pixels from end of visible area to start of sync |
| h_width | output | 12 | Horizontal sync length |
| v_blank | output | 12 | Vertical blanking length |
| v_offset | output | 12 | Lines from end of visible area to start of sync |
| v_width | output | 12 | Vertical sync length |

## Verification
The full reset timing is traced over its first two lines. This separates the wrap point of the pixel counter from the line step, and it places the horizontal pulse at its large default offsets.

A small timing on a second instance carries the frame-level tests:

- A negative-polarity setup shows whether the polarity inversion is applied.
- The degenerate one-pixel, one-line, two-period timing exercises every edge at once. Here sync starts as soon as the visible area ends and runs to the wrap.
- An illegal write followed by a legal one within the same frame shows that only the pending copy held at the wrap counts.

Random legal and illegal timings are then written at random points in the frame. Every clock is compared with a model that knows only the frame boundary, so writes that land late in a frame separate correct promotion from early adoption.

// File: rtl/rt_pkg.sv
package rt_pkg;

  localparam int RT_CW = 12;

  typedef logic [RT_CW-1:0] coord_t;

  // One axis of a raster: visible end, sync edges, period
  typedef struct packed {
    coord_t disp;
    coord_t sstart;
    coord_t send;
    coord_t total;
  } axis_cfg_t;

  // Edge order check for one axis
  function automatic logic axis_legal(axis_cfg_t c);
    return (c.disp != '0) && (c.sstart >= c.disp) &&
           (c.send > c.sstart) && (c.send <= c.total);
  endfunction

  function automatic coord_t axis_blank(axis_cfg_t c);
    return c.total - c.disp;
  endfunction

  function automatic coord_t axis_offset(axis_cfg_t c);
    return c.sstart - c.disp;
  endfunction

  function automatic coord_t axis_width(axis_cfg_t c);
    return c.send - c.sstart;
  endfunction

  // Half-open window test lo <= p < hi
  function automatic logic in_window(coord_t p, coord_t lo, coord_t hi);
    return (p >= lo) && (p < hi);
  endfunction

endpackage

// File: rtl/rt_axis_counter.sv
module rt_axis_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] total,
  output logic [W-1:0] pos,
  output logic         wrap
);

  localparam logic [W-1:0] ONE = W'(1);

  assign wrap = adv && (pos >= total - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)    pos <= '0;
    else if (wrap) pos <= '0;
    else if (adv)  pos <= pos + ONE;
  end

endmodule

// File: rtl/rt_axis_decode.sv
module rt_axis_decode
  import rt_pkg::*;
(
  input  coord_t pos,
  input  coord_t disp,
  input  coord_t sstart,
  input  coord_t send,
  input  logic   pol_pos,
  output logic   in_disp,
  output logic   pulse,
  output logic   sync_out
);

  assign in_disp  = (pos < disp);
  assign pulse    = in_window(pos, sstart, send);
  assign sync_out = pol_pos ? pulse : ~pulse;

endmodule

// File: rtl/rt_cfg_shadow.sv
module rt_cfg_shadow
  import rt_pkg::*;
#(
  parameter axis_cfg_t DEF_H    = '0,
  parameter axis_cfg_t DEF_V    = '0,
  parameter bit        DEF_HPOS = 1'b1,
  parameter bit        DEF_VPOS = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  axis_cfg_t new_h,
  input  axis_cfg_t new_v,
  input  logic      new_hpos,
  input  logic      new_vpos,
  input  logic      frame_wrap,
  output axis_cfg_t act_h,
  output axis_cfg_t act_v,
  output logic      act_hpos,
  output logic      act_vpos,
  output logic      cfg_error
);

  axis_cfg_t pend_h, pend_v;
  logic      pend_hpos, pend_vpos;
  logic      pend_ok;

  assign pend_ok   = axis_legal(pend_h) && axis_legal(pend_v);
  assign cfg_error = ~pend_ok;

  // Pending copy: any write lands here
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_h    <= DEF_H;
      pend_v    <= DEF_V;
      pend_hpos <= DEF_HPOS;
      pend_vpos <= DEF_VPOS;
    end else if (wr) begin
      pend_h    <= new_h;
      pend_v    <= new_v;
      pend_hpos <= new_hpos;
      pend_vpos <= new_vpos;
    end
  end

  // Working copy: promoted only at a frame wrap, only when legal
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_h    <= DEF_H;
      act_v    <= DEF_V;
      act_hpos <= DEF_HPOS;
      act_vpos <= DEF_VPOS;
    end else if (frame_wrap && pend_ok) begin
      act_h    <= pend_h;
      act_v    <= pend_v;
      act_hpos <= pend_hpos;
      act_vpos <= pend_vpos;
    end
  end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rt_pkg::*;
#(
  parameter int DEF_HDISP   = 1920,
  parameter int DEF_HSSTART = 2008,
  parameter int DEF_HSEND   = 2052,
  parameter int DEF_HTOTAL  = 2200,
  parameter int DEF_VDISP   = 1080,
  parameter int DEF_VSSTART = 1084,
  parameter int DEF_VSEND   = 1089,
  parameter int DEF_VTOTAL  = 1125,
  parameter bit DEF_HSYNC_POS = 1'b1,
  parameter bit DEF_VSYNC_POS = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_write,
  input  logic [RT_CW-1:0]   cfg_hdisp,
  input  logic [RT_CW-1:0]   cfg_hsync_start,
  input  logic [RT_CW-1:0]   cfg_hsync_end,
  input  logic [RT_CW-1:0]   cfg_htotal,
  input  logic [RT_CW-1:0]   cfg_vdisp,
  input  logic [RT_CW-1:0]   cfg_vsync_start,
  input  logic [RT_CW-1:0]   cfg_vsync_end,
  input  logic [RT_CW-1:0]   cfg_vtotal,
  input  logic               cfg_hsync_pos,
  input  logic               cfg_vsync_pos,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic               frame_start,
  output logic [RT_CW-1:0]   pix_x,
  output logic [RT_CW-1:0]   pix_y,
  output logic               cfg_error,
  output logic [RT_CW-1:0]   h_blank,
  output logic [RT_CW-1:0]   h_offset,
  output logic [RT_CW-1:0]   h_width,
  output logic [RT_CW-1:0]   v_blank,
  output logic [RT_CW-1:0]   v_offset,
  output logic [RT_CW-1:0]   v_width
);

  localparam int NAXIS = 2;

  localparam axis_cfg_t DEF_H = '{disp: coord_t'(DEF_HDISP), sstart: coord_t'(DEF_HSSTART),
                                  send: coord_t'(DEF_HSEND),  total:  coord_t'(DEF_HTOTAL)};
  localparam axis_cfg_t DEF_V = '{disp: coord_t'(DEF_VDISP), sstart: coord_t'(DEF_VSSTART),
                                  send: coord_t'(DEF_VSEND),  total:  coord_t'(DEF_VTOTAL)};

  axis_cfg_t act_h, act_v;
  logic      act_hpos, act_vpos;
  logic      h_wrap, v_wrap;
  logic      frame_wrap;   // last pixel of last line: promotion point
  logic      hs_pulse;     // horizontal pulse before polarity

  axis_cfg_t        axis_cfg [NAXIS];
  coord_t           axis_pos [NAXIS];
  logic [NAXIS-1:0] axis_pol;
  logic [NAXIS-1:0] axis_in_disp;
  logic [NAXIS-1:0] axis_pulse;
  logic [NAXIS-1:0] axis_sync;

  rt_cfg_shadow #(
    .DEF_H(DEF_H), .DEF_V(DEF_V),
    .DEF_HPOS(DEF_HSYNC_POS), .DEF_VPOS(DEF_VSYNC_POS)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr(cfg_write),
    .new_h('{disp: cfg_hdisp, sstart: cfg_hsync_start, send: cfg_hsync_end, total: cfg_htotal}),
    .new_v('{disp: cfg_vdisp, sstart: cfg_vsync_start, send: cfg_vsync_end, total: cfg_vtotal}),
    .new_hpos(cfg_hsync_pos), .new_vpos(cfg_vsync_pos),
    .frame_wrap(frame_wrap),
    .act_h(act_h), .act_v(act_v), .act_hpos(act_hpos), .act_vpos(act_vpos),
    .cfg_error(cfg_error)
  );

  // Pixel counter runs every clock; line counter steps on pixel wrap
  rt_axis_counter #(.W(RT_CW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .adv(1'b1), .total(act_h.total),
    .pos(pix_x), .wrap(h_wrap)
  );

  rt_axis_counter #(.W(RT_CW)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .adv(h_wrap), .total(act_v.total),
    .pos(pix_y), .wrap(v_wrap)
  );

  assign frame_wrap = h_wrap && v_wrap;

  assign axis_cfg[0] = act_h;
  assign axis_cfg[1] = act_v;
  assign axis_pos[0] = pix_x;
  assign axis_pos[1] = pix_y;
  assign axis_pol    = {act_vpos, act_hpos};

  for (genvar a = 0; a < NAXIS; a++) begin : g_axis
    rt_axis_decode u_dec (
      .pos(axis_pos[a]),
      .disp(axis_cfg[a].disp), .sstart(axis_cfg[a].sstart), .send(axis_cfg[a].send),
      .pol_pos(axis_pol[a]),
      .in_disp(axis_in_disp[a]), .pulse(axis_pulse[a]), .sync_out(axis_sync[a])
    );
  end

  assign hs_pulse    = axis_pulse[0];
  assign hsync       = axis_sync[0];
  assign vsync       = axis_sync[1];
  assign de          = &axis_in_disp;
  assign frame_start = (pix_x == '0) && (pix_y == '0);

  assign h_blank  = axis_blank(act_h);
  assign h_offset = axis_offset(act_h);
  assign h_width  = axis_width(act_h);
  assign v_blank  = axis_blank(act_v);
  assign v_offset = axis_offset(act_v);
  assign v_width  = axis_width(act_v);

endmodule

// File: rtl/rt_checker.sv
module rt_checker
  import rt_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input coord_t    pix_x,
  input coord_t    pix_y,
  input logic      de,
  input logic      frame_start,
  input logic      frame_wrap,
  input logic      hs_pulse,
  input logic      cfg_error,
  input axis_cfg_t act_h,
  input axis_cfg_t act_v
);

  assert_x_in_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_x < act_h.total);

  assert_y_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x == act_h.total - 1'b1 && pix_y != act_v.total - 1'b1)
      |=> pix_y == coord_t'($past(pix_y) + 1'b1));

  assert_de_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de) |-> pix_x == '0);

  assert_hs_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_pulse) |-> pix_x == act_h.sstart);

  assert_fs_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  assert_hold_midframe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> ($stable(act_h) && $stable(act_v)));

  assert_keep_on_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wrap && cfg_error) |=> ($stable(act_h) && $stable(act_v)));

endmodule

bind raster_timing_gen rt_checker u_rt_checker (
  .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y), .de(de),
  .frame_start(frame_start), .frame_wrap(frame_wrap), .hs_pulse(hs_pulse),
  .cfg_error(cfg_error), .act_h(act_h), .act_v(act_v)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit chk_en = 0;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  localparam int DEF_FULL [8] = '{1920, 2008, 2052, 2200, 1080, 1084, 1089, 1125};
  localparam int DEF_SMALL[8] = '{8, 10, 12, 16, 4, 5, 7, 9};

  // Drive side for the small instance
  int   drv[8] = DEF_SMALL;
  logic drv_hp = 1, drv_vp = 1, wr = 0;

  // Outputs of both instances
  logic f_hs, f_vs, f_de, f_fs, f_err;
  logic [11:0] f_x, f_y, f_hb, f_ho, f_hw, f_vb, f_vo, f_vw;
  logic s_hs, s_vs, s_de, s_fs, s_err;
  logic [11:0] s_x, s_y, s_hb, s_ho, s_hw, s_vb, s_vo, s_vw;

  raster_timing_gen u_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .cfg_write(1'b0),
    .cfg_hdisp(12'd0), .cfg_hsync_start(12'd0), .cfg_hsync_end(12'd0), .cfg_htotal(12'd0),
    .cfg_vdisp(12'd0), .cfg_vsync_start(12'd0), .cfg_vsync_end(12'd0), .cfg_vtotal(12'd0),
    .cfg_hsync_pos(1'b0), .cfg_vsync_pos(1'b0),
    .hsync(f_hs), .vsync(f_vs), .de(f_de), .frame_start(f_fs), .pix_x(f_x), .pix_y(f_y),
    .cfg_error(f_err), .h_blank(f_hb), .h_offset(f_ho), .h_width(f_hw),
    .v_blank(f_vb), .v_offset(f_vo), .v_width(f_vw)
  );

  raster_timing_gen #(
    .DEF_HDISP(8), .DEF_HSSTART(10), .DEF_HSEND(12), .DEF_HTOTAL(16),
    .DEF_VDISP(4), .DEF_VSSTART(5), .DEF_VSEND(7), .DEF_VTOTAL(9)
  ) u_raster_timing_gen_small (
    .clk(clk), .rst_n(rst_n), .cfg_write(wr),
    .cfg_hdisp(12'(drv[0])), .cfg_hsync_start(12'(drv[1])),
    .cfg_hsync_end(12'(drv[2])), .cfg_htotal(12'(drv[3])),
    .cfg_vdisp(12'(drv[4])), .cfg_vsync_start(12'(drv[5])),
    .cfg_vsync_end(12'(drv[6])), .cfg_vtotal(12'(drv[7])),
    .cfg_hsync_pos(drv_hp), .cfg_vsync_pos(drv_vp),
    .hsync(s_hs), .vsync(s_vs), .de(s_de), .frame_start(s_fs), .pix_x(s_x), .pix_y(s_y),
    .cfg_error(s_err), .h_blank(s_hb), .h_offset(s_ho), .h_width(s_hw),
    .v_blank(s_vb), .v_offset(s_vo), .v_width(s_vw)
  );

  // ---------------- reference model ----------------
  function automatic bit legal(int c[8]);
    return c[0] >= 1 && c[1] >= c[0] && c[2] > c[1] && c[2] <= c[3] &&
           c[4] >= 1 && c[5] >= c[4] && c[6] > c[5] && c[6] <= c[7];
  endfunction

  int cur[8], pend[8];
  bit cur_hp, cur_vp, pend_hp, pend_vp;
  int t, td;

  // Model advances on each edge: frame wrap uses the pending copy held before the edge
  always @(posedge clk) begin
    if (!rst_n) begin
      cur = DEF_SMALL; pend = DEF_SMALL;
      cur_hp = 1; cur_vp = 1; pend_hp = 1; pend_vp = 1;
      t = 0; td = 0;
    end else begin
      td++;
      t++;
      if (t == cur[3] * cur[7]) begin
        t = 0;
        if (legal(pend)) begin
          cur = pend; cur_hp = pend_hp; cur_vp = pend_vp;
        end
      end
      if (wr) begin
        pend = drv; pend_hp = drv_hp; pend_vp = drv_vp;
      end
    end
  end

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_frame(string who, int c[8], bit hp, bit vp, int tt,
                             int ax, int ay, bit ade, bit ahs, bit avs, bit afs,
                             int hb, int ho, int hw, int vb, int vo, int vw);
    int x = tt % c[3];
    int y = tt / c[3];
    bit hpul = (x >= c[1]) && (x < c[2]);
    bit vpul = (y >= c[5]) && (y < c[6]);
    cmp({who, " R1 pix_x"}, ax, x);
    cmp({who, " R2 pix_y"}, ay, y);
    cmp({who, " R3 de"}, int'(ade), int'(x < c[0] && y < c[4]));
    if (hp) cmp({who, " R4 hsync"}, int'(ahs), int'(hpul));
    else    cmp({who, " R5 hsync"}, int'(ahs), int'(!hpul));
    if (vp) cmp({who, " R4 vsync"}, int'(avs), int'(vpul));
    else    cmp({who, " R5 vsync"}, int'(avs), int'(!vpul));
    cmp({who, " R6 frame_start"}, int'(afs), int'(x == 0 && y == 0));
    cmp({who, " R8 h_blank"},  hb, c[3] - c[0]);
    cmp({who, " R8 h_offset"}, ho, c[1] - c[0]);
    cmp({who, " R8 h_width"},  hw, c[2] - c[1]);
    cmp({who, " R8 v_blank"},  vb, c[7] - c[4]);
    cmp({who, " R8 v_offset"}, vo, c[5] - c[4]);
    cmp({who, " R8 v_width"},  vw, c[6] - c[5]);
  endtask

  always @(negedge clk) begin
    if (chk_en && !done) begin
      // R9 and R10 are checked through every small-instance compare after a write
      check_frame("small", cur, cur_hp, cur_vp, t, s_x, s_y, s_de, s_hs, s_vs, s_fs,
                  s_hb, s_ho, s_hw, s_vb, s_vo, s_vw);
      cmp("small R10 cfg_error", int'(s_err), int'(!legal(pend)));
      if (td < 4500)
        check_frame("default R7", DEF_FULL, 1, 1, td, f_x, f_y, f_de, f_hs, f_vs, f_fs,
                    f_hb, f_ho, f_hw, f_vb, f_vo, f_vw);
    end
  end

  task automatic write_cfg(int c[8], bit hp, bit vp);
    @(negedge clk);
    drv = c; drv_hp = hp; drv_vp = vp; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int r[8];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R7 / R8: reset state of the full-size instance
    cmp("R7 reset pix_x", int'(f_x), 0);
    cmp("R7 reset pix_y", int'(f_y), 0);
    cmp("R6 reset frame_start", int'(f_fs), 1);
    cmp("R7 reset de", int'(f_de), 1);
    cmp("R7 reset hsync", int'(f_hs), 0);
    cmp("R7 reset vsync", int'(f_vs), 0);
    cmp("R7 reset cfg_error", int'(f_err), 0);
    cmp("R8 reset h_blank", int'(f_hb), 280);
    cmp("R8 reset h_offset", int'(f_ho), 88);
    cmp("R8 reset h_width", int'(f_hw), 44);
    cmp("R8 reset v_blank", int'(f_vb), 45);
    cmp("R8 reset v_offset", int'(f_vo), 4);
    cmp("R8 reset v_width", int'(f_vw), 5);
    rst_n = 1;
    chk_en = 1;
    repeat (4600) @(negedge clk);

    // R5: negative horizontal polarity
    write_cfg('{3, 4, 6, 7, 2, 3, 4, 5}, 1'b0, 1'b1);
    repeat (200) @(negedge clk);
    // degenerate: sync right after visible area, to the wrap
    write_cfg('{1, 1, 2, 2, 1, 1, 2, 2}, 1'b1, 1'b0);
    repeat (50) @(negedge clk);
    // R10: illegal (sync start before visible end) keeps timing
    write_cfg('{5, 3, 6, 8, 2, 3, 4, 5}, 1'b0, 1'b0);
    repeat (200) @(negedge clk);
    // R9: illegal then legal inside one frame
    write_cfg('{4, 5, 5, 8, 2, 3, 4, 5}, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    write_cfg('{6, 6, 9, 9, 3, 4, 5, 6}, 1'b0, 1'b1);
    repeat (200) @(negedge clk);

    for (int i = 0; i < 60; i++) begin
      r[0] = 1 + int'($urandom % 10);
      r[1] = r[0] + int'($urandom % 4);
      r[2] = r[1] + 1 + int'($urandom % 5);
      r[3] = r[2] + int'($urandom % 4);
      r[4] = 1 + int'($urandom % 6);
      r[5] = r[4] + int'($urandom % 3);
      r[6] = r[5] + 1 + int'($urandom % 3);
      r[7] = r[6] + int'($urandom % 3);
      if ($urandom % 5 == 0) r[2] = r[1];
      if ($urandom % 7 == 0) r[7] = r[6] - 1;
      write_cfg(r, 1'($urandom % 2), 1'($urandom % 2));
      repeat (20 + int'($urandom % 580)) @(negedge clk);
    end
    finish_run();
  end

endmodule